// File: doc/BRIEF.md
# Four-Channel Converter Serial Load Interface

This block is the digital front end of a four-channel 12-bit converter. A host sends 16-bit words over a three-wire serial link: a data pin, a serial clock, and an active-low select. A separate active-low load strobe commits the last word shifted in to one of four channel code registers. The address field at the head of the word chooses the register. An active-low clear forces all four codes to zero or to midscale, and a select pin picks which. The four 12-bit codes are the outputs and drive the converter ladders.

Every pin is asynchronous to the system clock, so each one passes through a synchronizer of `SYNC_STAGES` flops. Serial clock rising edges and load strobe falling edges are then detected on the synchronized levels. The serial clock must therefore run well below the system clock. Clear acts on its synchronized level, with no edge needed, and it holds the channel codes for as long as it stays low.

Top module: `qdac_serial_if`

## Requirements
- R1: A word is 16 bits and is shifted in MSB first. Word bit 15:14 is the channel address (00 = channel 0 … 11 = channel 3), bits 13:12 are ignored, and bits 11:0 are the code.
- R2: One bit is taken from `sdi_i` on each rising edge of `sclk_i` while `cs_n_i` is low.
- R3: While `cs_n_i` is high, `sclk_i` edges do not change the shift register. A later load commits the word shifted before `cs_n_i` went high.
- R4: A falling edge of `ld_n_i` writes the code field into the addressed channel, whatever the level of `cs_n_i`.
- R5: A load leaves the three channels that are not addressed unchanged.
- R6: While `clr_n_i` is low, every channel reads 0x800 if `clr_mid_i` is high and 0x000 if it is low.
- R7: A clear does not alter the shift register, so a load after the clear ends still commits the word shifted before it.
- R8: A load falling edge that occurs while clear is active has no effect. After clear releases, the channels still hold the clear value.
- R9: After synchronous reset, all channel codes and the shift register are zero.
- R10: The two ignored bits of the word do not influence any channel code.
- R11: A channel changes on the (SYNC_STAGES+1)-th system clock rising edge after a `ld_n_i` falling edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| cs_n_i | input | 1 | Active-low select that enables shifting |
| ld_n_i | input | 1 | Active-low load strobe; a falling edge commits the word |
| clr_n_i | input | 1 | Active-low clear of all channels |
| clr_mid_i | input | 1 | Clear value select: 1 = midscale, 0 = zero |
| dac_code_o | output | NUM_CH × CODE_W | Channel codes, channel k at [k] |

## Verification
The in-RTL assertions check these rules on every cycle: a detected serial edge shifts exactly one bit, a blocked edge holds the register, a load writes only the addressed channel, an active clear forces the selected value and overrides a load, and a clear leaves the shift register untouched. Other properties are only visible end to end, so the bench scenarios show them. These are the MSB-first layout and address decode, the ignored bits, a word surviving a clear and blocked clocking, and the exact synchronizer latency from the load strobe pin to the output.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CH_DEFAULT   = 4;
    localparam int CODE_DEFAULT = 12;
    localparam int WORD_DEFAULT = 16;

    typedef struct packed {
        logic clr_mid;
        logic clr_n;
        logic ld_n;
        logic cs_n;
        logic sdi;
        logic sclk;
    } pins_t;

    localparam pins_t PINS_IDLE = '{clr_mid: 1'b0, clr_n: 1'b1, ld_n: 1'b1,
                                    cs_n: 1'b1, sdi: 1'b0, sclk: 1'b0};

    function automatic logic [31:0] clear_value(input logic mid, input int width);
        clear_value = mid ? (32'd1 << (width - 1)) : 32'd0;
    endfunction

endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
        end else begin
            stage_q[0] <= pin_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_shift_reg.sv
module qdac_shift_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         cs_hi_i,
    input  logic         din_i,
    output logic [W-1:0] q_o
);
    logic shift_go;
    assign shift_go = step_i & ~cs_hi_i;

    always_ff @(posedge clk) begin
        if (rst)           q_o <= '0;
        else if (shift_go) q_o <= {q_o[W-2:0], din_i};
    end

    // R2: an enabled serial edge moves in one bit at the LSB
    p_shift_one_r2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !cs_hi_i) |=> (q_o == {$past(q_o[W-2:0]), $past(din_i)}));

    // R3: no shifting while select is high
    p_cs_block_r3: assert property (@(posedge clk) disable iff (rst)
        cs_hi_i |=> $stable(q_o));
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
    parameter int N  = 4,
    parameter int CW = 12,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [CW-1:0]        code_i,
    input  logic                 clr_i,
    input  logic                 clr_mid_i,
    output logic [N-1:0][CW-1:0] code_o
);
    logic [CW-1:0] clr_val;
    assign clr_val = CW'(qdac_pkg::clear_value(clr_mid_i, CW));

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                                  code_o[i] <= '0;
            else if (clr_i)                           code_o[i] <= clr_val;
            else if (load_i && (addr_i == AW'(i)))    code_o[i] <= code_i;
        end

        // R4: an addressed load writes the code
        p_write_r4: assert property (@(posedge clk) disable iff (rst)
            (load_i && !clr_i && addr_i == AW'(i)) |=> (code_o[i] == $past(code_i)));

        // R5: channels that are not addressed hold
        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (!clr_i && !(load_i && addr_i == AW'(i))) |=> $stable(code_o[i]));

        // R6 and R8: clear forces the selected value, overriding any load
        p_clear_r6: assert property (@(posedge clk) disable iff (rst)
            clr_i |=> (code_o[i] == ($past(clr_mid_i) ? CW'(1 << (CW-1)) : '0)));

        // R9: reset yields zero
        p_reset_r9: assert property (@(posedge clk)
            rst |=> (code_o[i] == '0));
    end
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if #(
    parameter int NUM_CH      = qdac_pkg::CH_DEFAULT,
    parameter int CODE_W      = qdac_pkg::CODE_DEFAULT,
    parameter int WORD_W      = qdac_pkg::WORD_DEFAULT,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sclk_i,
    input  logic                          sdi_i,
    input  logic                          cs_n_i,
    input  logic                          ld_n_i,
    input  logic                          clr_n_i,
    input  logic                          clr_mid_i,
    output logic [NUM_CH-1:0][CODE_W-1:0] dac_code_o
);
    import qdac_pkg::*;

    pins_t raw_pins, syn_pins;
    assign raw_pins = '{clr_mid: clr_mid_i, clr_n: clr_n_i, ld_n: ld_n_i,
                        cs_n: cs_n_i, sdi: sdi_i, sclk: sclk_i};

    qdac_pin_sync #(
        .WIDTH  ($bits(pins_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (raw_pins),
        .level_o(syn_pins)
    );

    logic sclk_q, ld_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            ld_q   <= 1'b1;
        end else begin
            sclk_q <= syn_pins.sclk;
            ld_q   <= syn_pins.ld_n;
        end
    end

    logic sclk_rise, ld_fall, clr_act;
    assign sclk_rise = syn_pins.sclk & ~sclk_q;
    assign ld_fall   = ld_q & ~syn_pins.ld_n;
    assign clr_act   = ~syn_pins.clr_n;

    logic [WORD_W-1:0] shift_word;

    qdac_shift_reg #(.W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .step_i (sclk_rise),
        .cs_hi_i(syn_pins.cs_n),
        .din_i  (syn_pins.sdi),
        .q_o    (shift_word)
    );

    qdac_chan_bank #(.N(NUM_CH), .CW(CODE_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .load_i   (ld_fall),
        .addr_i   (shift_word[WORD_W-1 -: ADDR_W]),
        .code_i   (shift_word[CODE_W-1:0]),
        .clr_i    (clr_act),
        .clr_mid_i(syn_pins.clr_mid),
        .code_o   (dac_code_o)
    );

    // R7: clear never disturbs the shift register
    p_clr_keeps_word_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_act && !sclk_rise) |=> $stable(shift_word));
endmodule

// File: tb/qdac_serial_if_tb.sv
module qdac_serial_if_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
    logic [3:0][11:0] code;
    logic [11:0] exp_code [4];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qdac_serial_if u_dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
        .ld_n_i(ld_n), .clr_n_i(clr_n), .clr_mid_i(clr_mid), .dac_code_o(code)
    );

    // word = {addr[1:0], ignored[1:0], code[11:0]}
    localparam logic [15:0] VEC [8] = '{
        16'h0ABC, 16'h5123, 16'h8FFF, 16'hF001,
        16'h3800, 16'h6555, 16'hA7FE, 16'hCAAA
    };

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_word(input logic [15:0] w, input logic cs_level, input bit keep_cs);
        @(negedge clk);
        cs_n = cs_level;
        idle(3);
        for (int i = 15; i >= 0; i--) begin
            sdi = w[i]; sclk = 1'b0; idle(3);
            sclk = 1'b1; idle(3);
        end
        sclk = 1'b0; idle(3);
        if (!keep_cs) cs_n = 1'b1;
        idle(3);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ld_n = 1'b0; idle(4);
        ld_n = 1'b1; idle(4);
    endtask

    task automatic check_ch(input int ch, input logic [11:0] exp, input string req);
        checks++;
        if (code[ch] !== exp) begin
            errors++;
            $display("FAIL %s ch%0d actual=%03h expected=%03h", req, ch, code[ch], exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < 4; c++) check_ch(c, exp_code[c], req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) exp_code[c] = 12'h000;
        idle(5);
        rst = 1'b0;
        idle(5);
        check_all("R9 reset");
        pulse_load();                 // R9: shift register is zero too
        check_all("R9 shift zero");

        // R1 R2 R5 R10: table walk, ignored bits vary
        for (int v = 0; v < 8; v++) begin
            shift_word(VEC[v], 1'b0, 1'b0);
            pulse_load();
            exp_code[VEC[v][15:14]] = VEC[v][11:0];
            check_all("R1/R2/R5/R10 table");
        end

        // R3: clocking with select high does not disturb the held word
        shift_word(16'h4321, 1'b0, 1'b0);
        shift_word(16'hCFED, 1'b1, 1'b0);
        pulse_load();
        exp_code[1] = 12'h321;
        check_all("R3 cs high blocks");

        // R4: load with select still low
        shift_word(16'h8246, 1'b0, 1'b1);
        pulse_load();
        cs_n = 1'b1;
        exp_code[2] = 12'h246;
        check_all("R4 load cs low");

        // R11: latency from ld_n falling edge
        shift_word(16'hC9A5, 1'b0, 1'b0);
        @(negedge clk);
        ld_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 check_ch(3, exp_code[3], "R11 not yet");
        @(posedge clk);
        #1 check_ch(3, 12'h9A5, "R11 updated");
        exp_code[3] = 12'h9A5;
        idle(3); ld_n = 1'b1; idle(4);

        // R6: clear to midscale, then to zero
        shift_word(16'h0777, 1'b0, 1'b0);
        @(negedge clk); clr_mid = 1'b1; clr_n = 1'b0; idle(5);
        for (int c = 0; c < 4; c++) check_ch(c, 12'h800, "R6 mid");
        clr_mid = 1'b0; idle(5);
        for (int c = 0; c < 4; c++) check_ch(c, 12'h000, "R6 zero");

        // R8: load during clear is dropped
        pulse_load();
        clr_n = 1'b1; idle(5);
        for (int c = 0; c < 4; c++) check_ch(c, 12'h000, "R8 clear priority");

        // R7: word shifted before clear still loads
        pulse_load();
        for (int c = 0; c < 4; c++) exp_code[c] = 12'h000;
        exp_code[0] = 12'h777;
        check_all("R7 shift kept");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule